// File: doc/BRIEF.md
# Dual compare-and-swap sequencer

This block runs an atomic compare-and-swap on two independent memory words. Each word is `DATA_W/8` bytes long and may start at any byte address, so each operand can straddle a page boundary and one operation can touch one to four distinct pages. Before any data access, the sequencer works out the set of distinct pages and probes a translation buffer for each one. It asks an external refill agent for every missing mapping.

A refill can push out a mapping that was already confirmed earlier in the same pass. For that reason the sequencer treats the set as confirmed only when every page hits in one uninterrupted pass. After any refill it starts again from the first page. A pass counter bounds the retries. Only after a clean pass does it raise the bus lock and issue two reads. If both loaded words equal their compare values, it issues two writes. Otherwise it releases the lock after the second read. A one-cycle done pulse reports the fault code, whether the swap happened, and both loaded values.

Top module: `dcas_seq`

## Requirements
- R1: The page of an address is `addr >> PAGE_W`. The candidate pages are taken in this order: the page of the first byte of operand 0, the page of its last byte (`addr0+DATA_W/8-1`), the page of the first byte of operand 1, and the page of its last byte. A candidate equal to an earlier one is dropped. The remaining pages are probed in that order, one per cycle, while `probe_req_o` is high.
- R2: A probe miss raises `refill_req_o` for the missed page. After `refill_done_i` arrives without error, probing restarts at the first page. Bus access starts only after a pass in which every page hits in consecutive probes.
- R3: The first pass is number 1. A miss during pass number `MAX_PASSES` ends the operation with fault code 3 and issues no further refill, so at most `MAX_PASSES-1` refills occur.
- R4: No bus request and no lock occur before a complete hit pass. No probe and no refill request occur while the lock is high.
- R5: A refill that returns `refill_err_i` ends the operation with fault code 1. A hit with `probe_wr_ok_i` low ends it with fault code 2. On any fault there is no bus access, `swapped_o` is 0, and both old values are 0.
- R6: Bus order is fixed: read `addr0`, read `addr1`, then write `new0` to `addr0` and `new1` to `addr1`. Each request is held until a one-cycle `bus_ack_i`, and read data is taken with that ack.
- R7: `bus_lock_o` rises together with the first read request. It stays high without a gap and falls in the cycle after the ack of the last access.
- R8: The writes happen only if the first loaded word equals `cmp0` and the second equals `cmp1`. Otherwise there is no write, the lock falls after the second read's ack, and `swapped_o` is 0.
- R9: `done_o` is a one-cycle pulse. In that cycle, `fault_o` and `fault_code_o` (0 none, 1 invalid, 2 write-protected, 3 livelock), `swapped_o`, `old0_o` and `old1_o` are valid.
- R10: `start_i` is ignored while an operation is in progress. The inputs are captured only when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start an operation (idle only) |
| addr0_i | input | ADDR_W | Byte address of operand 0 |
| addr1_i | input | ADDR_W | Byte address of operand 1 |
| cmp0_i | input | DATA_W | Compare value for operand 0 |
| cmp1_i | input | DATA_W | Compare value for operand 1 |
| new0_i | input | DATA_W | Swap value for operand 0 |
| new1_i | input | DATA_W | Swap value for operand 1 |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Operation aborted (valid with done) |
| fault_code_o | output | 2 | Fault reason |
| swapped_o | output | 1 | Both writes performed |
| old0_o | output | DATA_W | Loaded value of operand 0 |
| old1_o | output | DATA_W | Loaded value of operand 1 |
| probe_req_o | output | 1 | Translation probe valid |
| probe_page_o | output | ADDR_W-PAGE_W | Page being probed |
| probe_hit_i | input | 1 | Probe hit (same cycle) |
| probe_wr_ok_i | input | 1 | Hit mapping permits writes |
| refill_req_o | output | 1 | Refill request |
| refill_page_o | output | ADDR_W-PAGE_W | Page to load |
| refill_done_i | input | 1 | Refill finished |
| refill_err_i | input | 1 | Mapping invalid (with done) |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | ADDR_W | Access byte address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_lock_o | output | 1 | Bus lock |
| bus_ack_i | input | 1 | Access acknowledge |
| bus_rdata_i | input | DATA_W | Read data |

## Verification
The critical coincidence is a refill that completes in the same cycle as the eviction of a page that was already confirmed in the current pass. The bench provokes it with a two-entry FIFO translation model. The page needed first is preloaded as the oldest entry, so loading the second page pushes it out. The bench's behavioural model replays every probe and refill against its own copy of the buffer, then compares the full probe sequence, the refill count and the bus access log. A sequencer that trusted the stale first hit would show a shorter probe log and would start a read with a missing mapping.

// File: rtl/dcas_pkg.sv
package dcas_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PROBE, S_REFILL, S_RD0, S_RD1, S_WR0, S_WR1, S_DONE
  } state_e;

  typedef enum logic [1:0] {
    F_NONE     = 2'd0,
    F_INVALID  = 2'd1,
    F_WPROT    = 2'd2,
    F_LIVELOCK = 2'd3
  } fault_e;
endpackage

// File: rtl/dcas_pageset.sv
module dcas_pageset #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_W     = 12,
  parameter int OPND_BYTES = 4,
  localparam int VPN_W     = ADDR_W - PAGE_W
) (
  input  logic [ADDR_W-1:0]          addr0_i,
  input  logic [ADDR_W-1:0]          addr1_i,
  output logic [3:0][VPN_W-1:0]      pages_o,
  output logic [2:0]                 count_o
);
  logic [ADDR_W-1:0] end0, end1;
  logic [3:0][VPN_W-1:0] cand;
  logic [3:0] keep;

  assign end0 = addr0_i + ADDR_W'(OPND_BYTES - 1);
  assign end1 = addr1_i + ADDR_W'(OPND_BYTES - 1);

  // probe order: op0 first byte, op0 last byte, op1 first byte, op1 last byte
  assign cand[0] = addr0_i[ADDR_W-1:PAGE_W];
  assign cand[1] = end0[ADDR_W-1:PAGE_W];
  assign cand[2] = addr1_i[ADDR_W-1:PAGE_W];
  assign cand[3] = end1[ADDR_W-1:PAGE_W];

  generate
    for (genvar i = 0; i < 4; i++) begin : g_keep
      always_comb begin
        keep[i] = 1'b1;
        for (int j = 0; j < i; j++)
          if (cand[j] == cand[i]) keep[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    pages_o = '0;
    count_o = '0;
    for (int i = 0; i < 4; i++) begin
      if (keep[i]) begin
        pages_o[count_o[1:0]] = cand[i];
        count_o = count_o + 3'd1;
      end
    end
  end
endmodule

// File: rtl/dcas_cmp.sv
module dcas_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] ld0_i,
  input  logic [DATA_W-1:0] ld1_i,
  input  logic [DATA_W-1:0] cmp0_i,
  input  logic [DATA_W-1:0] cmp1_i,
  output logic              match_o
);
  assign match_o = (ld0_i == cmp0_i) && (ld1_i == cmp1_i);
endmodule

// File: rtl/dcas_pass_ctr.sv
module dcas_pass_ctr #(
  parameter int MAX_PASSES = 8,
  localparam int CNT_W     = $clog2(MAX_PASSES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CNT_W'(1);
    else if (clr_i)  cnt_q <= CNT_W'(1);
    else if (inc_i && !last_o) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(MAX_PASSES));
endmodule

// File: rtl/dcas_seq.sv
module dcas_seq
  import dcas_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int PAGE_W     = 12,
  parameter int MAX_PASSES = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        addr0_i,
  input  logic [ADDR_W-1:0]        addr1_i,
  input  logic [DATA_W-1:0]        cmp0_i,
  input  logic [DATA_W-1:0]        cmp1_i,
  input  logic [DATA_W-1:0]        new0_i,
  input  logic [DATA_W-1:0]        new1_i,
  output logic                     done_o,
  output logic                     fault_o,
  output logic [1:0]               fault_code_o,
  output logic                     swapped_o,
  output logic [DATA_W-1:0]        old0_o,
  output logic [DATA_W-1:0]        old1_o,
  output logic                     probe_req_o,
  output logic [ADDR_W-PAGE_W-1:0] probe_page_o,
  input  logic                     probe_hit_i,
  input  logic                     probe_wr_ok_i,
  output logic                     refill_req_o,
  output logic [ADDR_W-PAGE_W-1:0] refill_page_o,
  input  logic                     refill_done_i,
  input  logic                     refill_err_i,
  output logic                     bus_req_o,
  output logic                     bus_we_o,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic [DATA_W-1:0]        bus_wdata_o,
  output logic                     bus_lock_o,
  input  logic                     bus_ack_i,
  input  logic [DATA_W-1:0]        bus_rdata_i
);
  localparam int VPN_W      = ADDR_W - PAGE_W;
  localparam int OPND_BYTES = DATA_W / 8;

  state_e             state_q;
  fault_e             fault_q;
  logic [ADDR_W-1:0]  a0_q, a1_q;
  logic [DATA_W-1:0]  c0_q, c1_q, n0_q, n1_q, old0_q, old1_q;
  logic [1:0]         idx_q;
  logic               swapped_q;

  logic [3:0][VPN_W-1:0] pages;
  logic [2:0]         npages;
  logic               match, pass_last, pass_clr, pass_inc, last_idx;

  dcas_pageset #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OPND_BYTES(OPND_BYTES)
  ) u_pageset (
    .addr0_i(a0_q), .addr1_i(a1_q), .pages_o(pages), .count_o(npages)
  );

  // second operand compared straight off the bus in the ack cycle
  dcas_cmp #(.DATA_W(DATA_W)) u_cmp (
    .ld0_i(old0_q), .ld1_i(bus_rdata_i), .cmp0_i(c0_q), .cmp1_i(c1_q),
    .match_o(match)
  );

  assign pass_clr = (state_q == S_IDLE) && start_i;
  assign pass_inc = (state_q == S_REFILL) && refill_done_i && !refill_err_i;

  dcas_pass_ctr #(.MAX_PASSES(MAX_PASSES)) u_pass (
    .clk_i, .rst_ni, .clr_i(pass_clr), .inc_i(pass_inc), .last_o(pass_last)
  );

  assign last_idx = ({1'b0, idx_q} == (npages - 3'd1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      fault_q   <= F_NONE;
      a0_q      <= '0;
      a1_q      <= '0;
      c0_q      <= '0;
      c1_q      <= '0;
      n0_q      <= '0;
      n1_q      <= '0;
      old0_q    <= '0;
      old1_q    <= '0;
      idx_q     <= '0;
      swapped_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          a0_q      <= addr0_i;
          a1_q      <= addr1_i;
          c0_q      <= cmp0_i;
          c1_q      <= cmp1_i;
          n0_q      <= new0_i;
          n1_q      <= new1_i;
          old0_q    <= '0;
          old1_q    <= '0;
          idx_q     <= '0;
          fault_q   <= F_NONE;
          swapped_q <= 1'b0;
          state_q   <= S_PROBE;
        end
        S_PROBE: begin
          if (probe_hit_i) begin
            if (!probe_wr_ok_i) begin
              fault_q <= F_WPROT;
              state_q <= S_DONE;
            end else if (last_idx) begin
              state_q <= S_RD0;
            end else begin
              idx_q <= idx_q + 2'd1;
            end
          end else if (pass_last) begin
            fault_q <= F_LIVELOCK;
            state_q <= S_DONE;
          end else begin
            state_q <= S_REFILL;
          end
        end
        S_REFILL: if (refill_done_i) begin
          if (refill_err_i) begin
            fault_q <= F_INVALID;
            state_q <= S_DONE;
          end else begin
            idx_q   <= '0;  // a refill may have evicted a confirmed page
            state_q <= S_PROBE;
          end
        end
        S_RD0: if (bus_ack_i) begin
          old0_q  <= bus_rdata_i;
          state_q <= S_RD1;
        end
        S_RD1: if (bus_ack_i) begin
          old1_q  <= bus_rdata_i;
          state_q <= match ? S_WR0 : S_DONE;
        end
        S_WR0: if (bus_ack_i) state_q <= S_WR1;
        S_WR1: if (bus_ack_i) begin
          swapped_q <= 1'b1;
          state_q   <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o       = (state_q == S_DONE);
  assign fault_o      = (fault_q != F_NONE);
  assign fault_code_o = fault_q;
  assign swapped_o    = swapped_q;
  assign old0_o       = old0_q;
  assign old1_o       = old1_q;

  assign probe_req_o   = (state_q == S_PROBE);
  assign probe_page_o  = pages[idx_q];
  assign refill_req_o  = (state_q == S_REFILL);
  assign refill_page_o = pages[idx_q];

  assign bus_req_o   = (state_q == S_RD0) || (state_q == S_RD1) ||
                       (state_q == S_WR0) || (state_q == S_WR1);
  assign bus_we_o    = (state_q == S_WR0) || (state_q == S_WR1);
  assign bus_addr_o  = ((state_q == S_RD0) || (state_q == S_WR0)) ? a0_q : a1_q;
  assign bus_wdata_o = (state_q == S_WR0) ? n0_q : n1_q;
  assign bus_lock_o  = bus_req_o;
endmodule

// File: rtl/dcas_chk.sv
module dcas_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic done_o,
  input logic fault_o,
  input logic swapped_o,
  input logic probe_req_o,
  input logic refill_req_o,
  input logic bus_req_o,
  input logic bus_we_o,
  input logic bus_lock_o,
  input logic bus_ack_i
);
  logic       seen_lock_q;
  logic [2:0] wr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_lock_q <= 1'b0;
      wr_cnt_q    <= '0;
    end else if (done_o) begin
      seen_lock_q <= 1'b0;
      wr_cnt_q    <= '0;
    end else begin
      if (bus_lock_o) seen_lock_q <= 1'b1;
      if (bus_req_o && bus_we_o && bus_ack_i) wr_cnt_q <= wr_cnt_q + 3'd1;
    end
  end

  // R4
  a_r4_no_probe_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_lock_o |-> !probe_req_o && !refill_req_o);

  // R5
  a_r5_fault_never_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> !seen_lock_q && !swapped_o);

  // R7
  a_r7_lock_rises_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_lock_o) |-> bus_req_o && !bus_we_o);

  a_r7_lock_falls_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_lock_o) |-> $past(bus_ack_i));

  // R8
  a_r8_two_writes_or_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (swapped_o ? (wr_cnt_q == 3'd2) : (wr_cnt_q == 3'd0)));

  // R9
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind dcas_seq dcas_chk u_chk (.*);

// File: tb/tb_dcas_seq.sv
module tb_dcas_seq;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int PW = 12;
  localparam int VW = AW - PW;
  localparam int MP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start_i = 1'b0;
  logic [AW-1:0] addr0_i = '0, addr1_i = '0;
  logic [DW-1:0] cmp0_i = '0, cmp1_i = '0, new0_i = '0, new1_i = '0;
  logic          done_o, fault_o, swapped_o;
  logic [1:0]    fault_code_o;
  logic [DW-1:0] old0_o, old1_o;
  logic          probe_req_o, refill_req_o;
  logic [VW-1:0] probe_page_o, refill_page_o;
  logic          probe_hit_i = 1'b0, probe_wr_ok_i = 1'b0;
  logic          refill_done_i = 1'b0, refill_err_i = 1'b0;
  logic          bus_req_o, bus_we_o, bus_lock_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o;
  logic          bus_ack_i = 1'b0;
  logic [DW-1:0] bus_rdata_i = '0;

  dcas_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .MAX_PASSES(MP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .addr0_i, .addr1_i, .cmp0_i, .cmp1_i,
    .new0_i, .new1_i, .done_o, .fault_o, .fault_code_o, .swapped_o, .old0_o,
    .old1_o, .probe_req_o, .probe_page_o, .probe_hit_i, .probe_wr_ok_i,
    .refill_req_o, .refill_page_o, .refill_done_i, .refill_err_i, .bus_req_o,
    .bus_we_o, .bus_addr_o, .bus_wdata_o, .bus_lock_o, .bus_ack_i, .bus_rdata_i
  );

  int checks = 0, errors = 0;

  // environment state
  int               cap = 4;
  logic [VW-1:0]    tlb_q[$];
  bit               bad_pg[logic [VW-1:0]];
  bit               wp_pg[logic [VW-1:0]];
  logic [DW-1:0]    mem[logic [AW-1:0]];
  int               bus_lat = 1;
  int               bc = 0, rc = 0;
  int               n_refills = 0, done_cnt = 0, lock_err = 0;
  logic [VW-1:0]    probe_log[$];
  logic [64:0]      acc_log[$];
  logic [1:0]       got_fc;
  logic             got_f, got_sw;
  logic [DW-1:0]    got_o0, got_o1;

  // expected, from the behavioural model
  logic [VW-1:0]    exp_probe[$];
  logic [64:0]      exp_acc[$];
  int               exp_ref;
  logic [1:0]       exp_fc;
  logic             exp_sw;
  logic [DW-1:0]    exp_o0, exp_o1, exp_m0, exp_m1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit in_q(input logic [VW-1:0] q[$], input logic [VW-1:0] p);
    foreach (q[i]) if (q[i] == p) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [DW-1:0] rd_mem(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  // environment responders, all driven on the falling edge
  always @(negedge clk) begin
    if (done_o) begin
      done_cnt++;
      got_f  = fault_o;  got_fc = fault_code_o; got_sw = swapped_o;
      got_o0 = old0_o;   got_o1 = old1_o;
    end
    if (bus_req_o && !bus_lock_o) lock_err++;
    if (bus_lock_o && (probe_req_o || refill_req_o)) lock_err++;
    if (probe_req_o) probe_log.push_back(probe_page_o);

    if (refill_done_i) begin
      refill_done_i = 1'b0; refill_err_i = 1'b0; rc = 0;
    end else if (refill_req_o) begin
      rc++;
      if (rc == 2) begin
        refill_done_i = 1'b1;
        n_refills++;
        if (bad_pg.exists(refill_page_o)) refill_err_i = 1'b1;
        else begin
          if (tlb_q.size() >= cap) void'(tlb_q.pop_front());
          tlb_q.push_back(refill_page_o);
        end
      end
    end

    if (bus_ack_i) begin
      bus_ack_i = 1'b0; bc = 0;
    end else if (bus_req_o) begin
      bc++;
      if (bc == bus_lat) begin
        bus_ack_i = 1'b1;
        if (bus_we_o) begin
          mem[bus_addr_o] = bus_wdata_o;
          acc_log.push_back({1'b1, bus_addr_o, bus_wdata_o});
        end else begin
          bus_rdata_i = rd_mem(bus_addr_o);
          acc_log.push_back({1'b0, bus_addr_o, bus_rdata_i});
        end
      end
    end

    probe_hit_i   = in_q(tlb_q, probe_page_o);
    probe_wr_ok_i = !wp_pg.exists(probe_page_o);
  end

  // reference model: replays passes on a copy of the translation buffer
  task automatic model(input logic [AW-1:0] a0, a1, input logic [DW-1:0] c0, c1, n0, n1);
    logic [VW-1:0] t[$];
    logic [VW-1:0] pl[$];
    logic [AW-1:0] ends[4];
    logic [VW-1:0] mp;
    int pass;
    bit miss, stop;
    logic [DW-1:0] r0, r1;
    t = tlb_q;
    exp_probe.delete(); exp_acc.delete();
    exp_ref = 0; exp_fc = 2'd0; exp_sw = 1'b0; exp_o0 = '0; exp_o1 = '0;
    ends[0] = a0; ends[1] = a0 + AW'(DW/8 - 1); ends[2] = a1; ends[3] = a1 + AW'(DW/8 - 1);
    foreach (ends[i]) if (!in_q(pl, ends[i][AW-1:PW])) pl.push_back(ends[i][AW-1:PW]);
    pass = 1; stop = 0;
    while (!stop) begin
      miss = 0;
      foreach (pl[i]) begin
        exp_probe.push_back(pl[i]);
        if (in_q(t, pl[i])) begin
          if (wp_pg.exists(pl[i])) begin exp_fc = 2'd2; stop = 1; break; end
        end else begin
          miss = 1; mp = pl[i]; break;
        end
      end
      if (stop || !miss) break;
      if (pass == MP) begin exp_fc = 2'd3; break; end
      exp_ref++;
      if (bad_pg.exists(mp)) begin exp_fc = 2'd1; break; end
      if (t.size() >= cap) void'(t.pop_front());
      t.push_back(mp);
      pass++;
    end
    exp_m0 = rd_mem(a0); exp_m1 = rd_mem(a1);
    if (exp_fc == 2'd0) begin
      r0 = rd_mem(a0); r1 = rd_mem(a1);
      exp_o0 = r0; exp_o1 = r1;
      exp_acc.push_back({1'b0, a0, r0});
      exp_acc.push_back({1'b0, a1, r1});
      if (r0 == c0 && r1 == c1) begin
        exp_sw = 1'b1;
        exp_acc.push_back({1'b1, a0, n0});
        exp_acc.push_back({1'b1, a1, n1});
        exp_m0 = n0; exp_m1 = n1;
      end
    end
  endtask

  task automatic run(input string tag, input logic [AW-1:0] a0, a1,
                     input logic [DW-1:0] c0, c1, n0, n1, input int lat, input bit restart);
    int d0, wd;
    bit same;
    model(a0, a1, c0, c1, n0, n1);
    bus_lat = lat;
    probe_log.delete(); acc_log.delete(); n_refills = 0; lock_err = 0;
    d0 = done_cnt;
    @(negedge clk);
    addr0_i = a0; addr1_i = a1; cmp0_i = c0; cmp1_i = c1; new0_i = n0; new1_i = n1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (restart) begin
      repeat (3) @(negedge clk);
      addr0_i = 32'h0005_0000; addr1_i = 32'h0006_0000;  // R10 must not be captured
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wd = 0;
    while (done_cnt == d0 && wd < 3000) begin @(posedge clk); wd++; end
    repeat (6) @(negedge clk);
    #1;
    chk(done_cnt == d0 + 1, "R9/R10", {tag, " done pulses"}, done_cnt - d0, 1);
    chk(got_fc == exp_fc && got_f == (exp_fc != 0), "R3/R5/R9", {tag, " fault code"}, got_fc, exp_fc);
    chk(n_refills == exp_ref, "R2/R3", {tag, " refill count"}, n_refills, exp_ref);
    same = (probe_log.size() == exp_probe.size());
    if (same) foreach (exp_probe[i]) if (probe_log[i] != exp_probe[i]) same = 0;
    chk(same, "R1/R2", {tag, " probe sequence"}, probe_log.size(), exp_probe.size());
    same = (acc_log.size() == exp_acc.size());
    if (same) foreach (exp_acc[i]) if (acc_log[i] != exp_acc[i]) same = 0;
    chk(same, "R4/R6", {tag, " bus access log"}, acc_log.size(), exp_acc.size());
    chk(got_sw == exp_sw, "R8", {tag, " swapped"}, got_sw, exp_sw);
    chk(got_o0 == exp_o0 && got_o1 == exp_o1, "R8/R9", {tag, " old values"},
        {got_o0, got_o1}, {exp_o0, exp_o1});
    chk(rd_mem(a0) == exp_m0 && rd_mem(a1) == exp_m1, "R6/R8", {tag, " memory"},
        {rd_mem(a0), rd_mem(a1)}, {exp_m0, exp_m1});
    chk(lock_err == 0, "R4/R7", {tag, " lock coverage"}, lock_err, 0);
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done_o && !bus_req_o && !bus_lock_o && !probe_req_o && !refill_req_o,
        "R9", "reset state", {done_o, bus_lock_o, probe_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // one page, match -> swap
    cap = 4; tlb_q.delete();
    mem[32'h1000] = 32'h11; mem[32'h1010] = 32'h22;
    run("r6_same_page", 32'h1000, 32'h1010, 32'h11, 32'h22, 32'hA1, 32'hA2, 1, 0);

    // two pages, first compare fails
    mem[32'h2000] = 32'h33; mem[32'h5000] = 32'h44;
    run("r8_mismatch", 32'h2000, 32'h5000, 32'h30, 32'h44, 32'hB1, 32'hB2, 2, 0);

    // second compare fails
    mem[32'h2004] = 32'h55; mem[32'h5004] = 32'h66;
    run("r8_mismatch_second", 32'h2004, 32'h5004, 32'h55, 32'h67, 32'hB3, 32'hB4, 1, 0);

    // both operands straddle pages: four distinct pages
    cap = 4; tlb_q.delete();
    mem[32'h3FFE] = 32'h77; mem[32'h7FFD] = 32'h88;
    run("r1_four_pages", 32'h3FFE, 32'h7FFD, 32'h77, 32'h88, 32'hC1, 32'hC2, 3, 0);

    // refill evicts a page already confirmed in this pass; stray start mid-operation
    cap = 2; tlb_q.delete(); tlb_q.push_back(20'hA); tlb_q.push_back(20'h99);
    mem[32'hA000] = 32'h1; mem[32'hB000] = 32'h2;
    run("r2_evict_restart", 32'hA000, 32'hB000, 32'h1, 32'h2, 32'hD1, 32'hD2, 1, 1);

    // more pages than the buffer holds
    cap = 2; tlb_q.delete();
    mem[32'h10FFE] = 32'h5; mem[32'h20FFE] = 32'h6;
    run("r3_livelock", 32'h10FFE, 32'h20FFE, 32'h5, 32'h6, 32'hE1, 32'hE2, 1, 0);

    // write-protected mapping
    cap = 4; tlb_q.delete(); wp_pg[20'h31] = 1'b1;
    mem[32'h30000] = 32'h9; mem[32'h31000] = 32'hA;
    run("r5_wprot", 32'h30000, 32'h31000, 32'h9, 32'hA, 32'hF1, 32'hF2, 1, 0);

    // invalid mapping
    tlb_q.delete(); bad_pg[20'h41] = 1'b1;
    mem[32'h40000] = 32'hB; mem[32'h41000] = 32'hC;
    run("r5_invalid", 32'h40000, 32'h41000, 32'hB, 32'hC, 32'h1F, 32'h2F, 2, 0);

    // all pages already present, operand 1 shares a page with operand 0's tail
    cap = 4; tlb_q.delete(); tlb_q.push_back(20'hC); tlb_q.push_back(20'hD);
    mem[32'hCFFE] = 32'hDEAD; mem[32'hD100] = 32'hBEEF;
    run("r1_preloaded", 32'hCFFE, 32'hD100, 32'hDEAD, 32'hBEEF, 32'h1234, 32'h5678, 2, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule